// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of recent branch directions and a table of 2-bit saturating counters. The fetch stage sends a lookup with a few PC bits. The table entry is chosen by XORing those PC bits with the current history. One cycle later the block returns the direction, which is the upper bit of that counter, together with the history value the lookup used. The history is shifted with the guessed direction at the same edge, so a second branch fetched straight after the first sees a different history.

The returned history snapshot travels down the pipeline with the branch. When the branch resolves, the execute stage sends it back with the branch's PC bits, the real direction and a mispredict flag. The counter at the index formed from the snapshot, not from the live history, moves one step toward the real direction. On a mispredict the history is rebuilt from the snapshot, shifted by one with the real direction. A fetch stall freezes the lookup path, and the predictor outputs keep their last value during the stall.

Top module: `gshare_dir_pred`

## Requirements
- R1: After reset the history is all zeros, every counter holds 01 (weakly not-taken), and predTaken and predHist are both 0.
- R2: A lookup reads the counter at index history XOR fetchPcIdx. fetchPcIdx carries the PC bits just above the instruction alignment bits, and its width equals the history width.
- R3: A lookup accepted at a clock edge sets predTaken to bit 1 (the upper bit) of the selected counter at that edge. predHist takes the history value the lookup used at the same edge.
- R4: Each accepted lookup without a concurrent mispredict shifts the history left by one and puts the predicted direction in bit 0.
- R5: A resolve steps the counter at index resolveHist XOR resolvePcIdx by one toward the actual direction. Taken increments the counter and not-taken decrements it.
- R6: A counter at 11 stays at 11 when trained taken. A counter at 00 stays at 00 when trained not-taken.
- R7: A resolve with the mispredict flag set loads the history with resolveHist shifted left by one, with resolveTaken in bit 0.
- R8: When a mispredict repair and an accepted lookup fall on the same edge, the repair sets the history and the lookup does not shift it. The lookup still produces its prediction.
- R9: While fetchStall is high, or lookupValid is low, predTaken, predHist and the history stay unchanged, unless a repair loads the history.
- R10: When a lookup and a training write hit the same counter on the same edge, the lookup returns the counter value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchStall | input | 1 | Fetch stall; blocks lookups |
| lookupValid | input | 1 | Lookup request from fetch |
| fetchPcIdx | input | IDX_W | PC bits above the alignment bits for the lookup |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHist | output | IDX_W | History snapshot used by the last lookup |
| resolveValid | input | 1 | A branch has resolved |
| resolveTaken | input | 1 | Actual direction of the resolved branch |
| resolveMispredict | input | 1 | The resolved branch was mispredicted |
| resolveHist | input | IDX_W | Snapshot returned with the resolved branch |
| resolvePcIdx | input | IDX_W | PC bits above the alignment bits of the resolved branch |

## Verification
The bench builds the predictor with IDX_W = 4, which gives a 16-entry table. At that size random PCs and outcomes alias often, so same-index read-write collisions, back-to-back lookups on one counter and counters driven into both saturation limits all occur within a few thousand cycles. With IDX_W = 4 the history also wraps every four shifts, so repair values and speculative shifts that lose the top bit are exercised many times.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic lookup;   // accepted lookup this cycle
    logic repair;   // history restore from a mispredicted branch
    logic train;    // counter update from a resolved branch
  } gshare_ctrl_t;
endpackage

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import gshare_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fetchStall,
  input  logic         lookupValid,
  input  logic         resolveValid,
  input  logic         resolveMispredict,
  output gshare_ctrl_t strobe
);
  always_comb begin
    strobe.lookup = lookupValid & ~fetchStall;
    strobe.repair = resolveValid & resolveMispredict;
    strobe.train  = resolveValid;
  end

  // R9: a stalled fetch never produces an accepted lookup
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fetchStall |-> !strobe.lookup);
  // R7: a repair always comes with a training write
  a_r7_repair_trains: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.repair |-> strobe.train);
endmodule

// File: rtl/gshare_hist.sv
module gshare_hist
  import gshare_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gshare_ctrl_t     strobe,
  input  logic             predDir,
  input  logic [IDX_W-1:0] resolveHist,
  input  logic             resolveTaken,
  output logic [IDX_W-1:0] ghr,
  output logic [IDX_W-1:0] predHist
);
  logic [IDX_W-1:0] ghrQ, snapQ;

  // Repair outranks the speculative shift (R8)
  always_ff @(posedge clk) begin
    if (!rst_n)
      ghrQ <= '0;
    else if (strobe.repair)
      ghrQ <= {resolveHist[IDX_W-2:0], resolveTaken};
    else if (strobe.lookup)
      ghrQ <= {ghrQ[IDX_W-2:0], predDir};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      snapQ <= '0;
    else if (strobe.lookup)
      snapQ <= ghrQ;
  end

  assign ghr      = ghrQ;
  assign predHist = snapQ;

  // R4: after a plain lookup, live history is the snapshot shifted by one
  a_r4_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.lookup && !strobe.repair |=> ghr[IDX_W-1:1] == predHist[IDX_W-2:0]);
  // R7, R8: repair wins and rebuilds from the returned snapshot
  a_r8_repair_wins: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.repair |=> ghr[IDX_W-1:1] == $past(resolveHist[IDX_W-2:0])
                      && ghr[0] == $past(resolveTaken));
  // R9: idle cycles leave history and snapshot alone
  a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.lookup && !strobe.repair |=> $stable(ghr) && $stable(predHist));
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gshare_ctrl_t     strobe,
  input  logic [IDX_W-1:0] ghr,
  input  logic [IDX_W-1:0] fetchPcIdx,
  input  logic [IDX_W-1:0] resolveHist,
  input  logic [IDX_W-1:0] resolvePcIdx,
  input  logic             resolveTaken,
  output logic             predDir,
  output logic             predTaken
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       cnt [DEPTH];
  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic [1:0]       rdVal, wrOld, wrNew;
  logic             predQ;

  assign rdIdx   = ghr ^ fetchPcIdx;
  assign wrIdx   = resolveHist ^ resolvePcIdx;
  assign rdVal   = cnt[rdIdx];   // old value on a same-index write (R10)
  assign wrOld   = cnt[wrIdx];
  assign predDir = rdVal[1];

  always_comb begin
    wrNew = wrOld;
    if (resolveTaken && wrOld != 2'b11)
      wrNew = wrOld + 2'b01;
    else if (!resolveTaken && wrOld != 2'b00)
      wrNew = wrOld - 2'b01;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (!rst_n)
        cnt[e] <= 2'b01;
      else if (strobe.train && wrIdx == IDX_W'(e))
        cnt[e] <= wrNew;
    end
  end

  // Read register: only an accepted lookup updates it (stall gating)
  always_ff @(posedge clk) begin
    if (!rst_n)
      predQ <= 1'b0;
    else if (strobe.lookup)
      predQ <= predDir;
  end

  assign predTaken = predQ;

  // R3: the output carries the direction read at the lookup edge
  a_r3_dir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.lookup |=> predTaken == $past(predDir));
  // R9: the read port holds while no lookup is accepted
  a_r9_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.lookup |=> $stable(predTaken));
  // R6: saturation at the top
  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.train && resolveTaken && wrOld == 2'b11 |=> cnt[$past(wrIdx)] == 2'b11);
  // R6: saturation at the bottom
  a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.train && !resolveTaken && wrOld == 2'b00 |=> cnt[$past(wrIdx)] == 2'b00);
  // R5: a taken update never lowers the counter
  a_r5_toward_taken: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.train && resolveTaken |=> cnt[$past(wrIdx)] >= $past(wrOld));
endmodule

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred
  import gshare_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetchStall,
  input  logic             lookupValid,
  input  logic [IDX_W-1:0] fetchPcIdx,
  output logic             predTaken,
  output logic [IDX_W-1:0] predHist,
  input  logic             resolveValid,
  input  logic             resolveTaken,
  input  logic             resolveMispredict,
  input  logic [IDX_W-1:0] resolveHist,
  input  logic [IDX_W-1:0] resolvePcIdx
);
  gshare_ctrl_t     strobe;
  logic [IDX_W-1:0] ghr;
  logic             predDir;

  gshare_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .fetchStall(fetchStall), .lookupValid(lookupValid),
    .resolveValid(resolveValid), .resolveMispredict(resolveMispredict), .strobe(strobe)
  );

  gshare_hist #(.IDX_W(IDX_W)) hist_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .predDir(predDir),
    .resolveHist(resolveHist), .resolveTaken(resolveTaken),
    .ghr(ghr), .predHist(predHist)
  );

  gshare_pht #(.IDX_W(IDX_W)) pht_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ghr(ghr), .fetchPcIdx(fetchPcIdx),
    .resolveHist(resolveHist), .resolvePcIdx(resolvePcIdx), .resolveTaken(resolveTaken),
    .predDir(predDir), .predTaken(predTaken)
  );
endmodule

// File: tb/gshare_dir_pred_tb_top.sv
module gshare_dir_pred_tb_top;
  localparam int W    = 4;
  localparam int N    = 1 << W;
  localparam int MASK = N - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetchStall = 1'b0, lookupValid = 1'b0;
  logic [W-1:0] fetchPcIdx = '0;
  logic predTaken;
  logic [W-1:0] predHist;
  logic resolveValid = 1'b0, resolveTaken = 1'b0, resolveMispredict = 1'b0;
  logic [W-1:0] resolveHist = '0, resolvePcIdx = '0;

  int errors = 0, checks = 0;
  int mPht [N];
  int mGhr = 0, expTaken = 0, expHist = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gshare_dir_pred #(.IDX_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetchStall(fetchStall), .lookupValid(lookupValid),
    .fetchPcIdx(fetchPcIdx), .predTaken(predTaken), .predHist(predHist),
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .resolveMispredict(resolveMispredict), .resolveHist(resolveHist),
    .resolvePcIdx(resolvePcIdx)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(bit lv, bit st, int pc, bit rv, bit rt, bit rm, int rh, int rpc);
    lookupValid = lv; fetchStall = st; fetchPcIdx = W'(pc);
    resolveValid = rv; resolveTaken = rt; resolveMispredict = rm;
    resolveHist = W'(rh); resolvePcIdx = W'(rpc);
  endtask

  // Model one edge from the driven inputs, then compare after the edge
  task automatic step(string tag);
    int rIdx, rVal, nGhr, wIdx;
    rIdx = (mGhr ^ int'(fetchPcIdx)) & MASK;
    rVal = mPht[rIdx];
    nGhr = mGhr;
    if (lookupValid && !fetchStall) begin
      expTaken = (rVal >= 2) ? 1 : 0;
      expHist  = mGhr;
      nGhr = ((mGhr << 1) | expTaken) & MASK;
    end
    if (resolveValid && resolveMispredict)
      nGhr = ((int'(resolveHist) << 1) | int'(resolveTaken)) & MASK;
    if (resolveValid) begin
      wIdx = (int'(resolveHist) ^ int'(resolvePcIdx)) & MASK;
      if (resolveTaken && mPht[wIdx] < 3) mPht[wIdx]++;
      else if (!resolveTaken && mPht[wIdx] > 0) mPht[wIdx]--;
    end
    mGhr = nGhr;
    @(posedge clk); #2;
    check(tag, "predTaken", int'(predTaken), expTaken);
    check(tag, "predHist", int'(predHist), expHist);
  endtask

  // Lookup aimed at a chosen table index under the current model history
  task automatic lookAt(string tag, int idx);
    drive(1, 0, (idx ^ mGhr) & MASK, 0, 0, 0, 0, 0);
    step(tag);
  endtask

  task automatic trainAt(string tag, int idx, bit tk);
    drive(0, 0, 0, 1, tk, 0, 0, idx);
    step(tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mPht[i] = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    check("R1", "predTaken after reset", int'(predTaken), 0);
    check("R1", "predHist after reset", int'(predHist), 0);

    // R1 R3: fresh counters predict not-taken
    drive(1, 0, 0, 0, 0, 0, 0, 0); step("R3");
    drive(1, 0, 9, 0, 0, 0, 0, 0); step("R1");

    // R7: force history to a known value
    drive(0, 0, 0, 1, 1, 1, 2, 3); step("R7");
    // R5: train index 7 up to taken
    trainAt("R5", 7, 1); trainAt("R5", 7, 1);
    // R2: lookup with pc giving index 7 predicts taken
    lookAt("R2", 7);
    // R4: back-to-back lookups see shifted history
    lookAt("R4", 7); lookAt("R4", 3); lookAt("R4", 7);

    // R6: top saturation then bottom saturation
    for (int k = 0; k < 3; k++) trainAt("R6", 7, 1);
    lookAt("R6", 7);
    trainAt("R6", 7, 0); lookAt("R6", 7);
    for (int k = 0; k < 5; k++) trainAt("R6", 7, 0);
    trainAt("R6", 7, 1); lookAt("R6", 7);
    trainAt("R6", 7, 1); lookAt("R6", 7);

    // R10: same-cycle write and read on index 5 (at 01 -> 10)
    drive(1, 0, (5 ^ mGhr) & MASK, 1, 1, 0, 5, 0); step("R10");
    lookAt("R10", 5);

    // R8: repair and lookup on the same edge
    drive(1, 0, 6, 1, 0, 1, 11, 2); step("R8");
    lookAt("R8", 2);

    // R9: stall with a pending lookup, then lookupValid low
    drive(1, 1, 3, 0, 0, 0, 0, 0); step("R9"); step("R9");
    drive(0, 0, 3, 0, 0, 0, 0, 0); step("R9");
    drive(1, 1, 1, 1, 1, 1, 4, 0); step("R9");
    lookAt("R9", 0);

    // Mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      drive(($urandom % 4) != 0, ($urandom % 5) == 0, $urandom % N,
            ($urandom % 2) == 0, $urandom % 2, ($urandom % 4) == 0,
            $urandom % N, $urandom % N);
      step("R5");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule